// File: doc/BRIEF.md
# RTC counter with alarm comparators

This block is a real-time-clock peripheral on a 32-bit register bus. A source pulse input comes in once per cycle of a 32768 Hz reference, already brought into the bus clock domain as a one-cycle enable. A programmable prescaler turns those pulses into counter steps. The counter is a 32-bit up-counter that software can write and that wraps around. Two alarm compare registers watch the counter. A status register holds three sticky event flags, which are cleared by writing 1, and three ordinary enable bits.

One interrupt output is driven from the flags and their enables. A two-bit clock-select register and a 32-bit scratch register complete the map. Software uses the scratch register to keep a count of counter wrap-arounds.

Reads are combinational from the addressed register. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The counter advances by one on every 2*(DIV+1)-th source pulse, where DIV is the divider register at offset 0x0C (lower 16 bits kept, upper bits read 0). A write to the divider restarts the prescaler phase, so the first step comes on the 2*(DIV+1)-th pulse after that write.
- R3: The counter at offset 0x00 is writable. A write in the same cycle as a step loads the written value, and no step happens in that cycle. Two reads between steps return the same value.
- R4: From 0xFFFFFFFF the counter steps to 0 and keeps running.
- R5: Alarm 0 (offset 0x04) sets status bit 0, and alarm 1 (offset 0x18) sets status bit 4. A flag sets only on a step that makes the counter equal to that alarm's value, and only while that alarm's enable is 1 (bit 2 for alarm 0, bit 6 for alarm 1). Loading a matching value by a counter write sets no flag.
- R6: Status bit 1, the tick flag, sets on every counter step, whatever its enable says.
- R7: A status (offset 0x08) write of 1 to flag bit 0, 1 or 4 clears that flag, and a write of 0 leaves it. Enable bits 2, 3 and 6 are plain read/write, and all other bits read 0. If a flag sets in the same cycle as it is written with 1, the flag stays set.
- R8: `irq` is 1 exactly when (bit0 and bit2) or (bit1 and bit3) or (bit4 and bit6) of the status register are both 1.
- R9: Clock select (offset 0x1C) keeps its lower 2 bits and reads 0 above them. Scratch (offset 0x40) keeps all 32 bits and is not changed by counting. Offset 0x14 and unmapped offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 1 | One-cycle pulse per reference clock period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The prescaler is driven with a divider of 0 and of 3. Counting pulses right up to, and one past, the step point separates an off-by-one in the 2*(DIV+1) period from a correct one. Alarms are tried with the enable off and on, and with a counter write that lands on the alarm value, to separate step-driven matching from plain equality. The flags are written with 0, with 1, and with 1 in the very cycle of a set, which exposes wrong clear priority. A cycle that has both a counter write and a step shows whether the write wins.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFS_COUNT   = 8'h00;
  localparam logic [7:0] OFS_ALARM0  = 8'h04;
  localparam logic [7:0] OFS_STATUS  = 8'h08;
  localparam logic [7:0] OFS_DIVIDER = 8'h0C;
  localparam logic [7:0] OFS_ALARM1  = 8'h18;
  localparam logic [7:0] OFS_CLKSEL  = 8'h1C;
  localparam logic [7:0] OFS_SCRATCH = 8'h40;

  localparam int NUM_ALARMS = 2;
  localparam int TICK_FLAG_BIT = 1;
  localparam int TICK_EN_BIT   = 3;
  localparam int CLKSEL_W      = 2;

  // status bit positions of each alarm's flag and enable
  function automatic int alarm_flag_bit(input int idx);
    return (idx == 0) ? 0 : 4;
  endfunction

  function automatic int alarm_en_bit(input int idx);
    return (idx == 0) ? 2 : 6;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_pulse,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick_o
);
  localparam int PH_W = DIV_W + 1;

  // last phase index of a 2*(div+1) long period
  function automatic logic [PH_W-1:0] last_phase(input logic [DIV_W-1:0] d);
    return {d, 1'b1};
  endfunction

  logic [PH_W-1:0] phase;

  assign tick_o = src_pulse && (phase >= last_phase(div));

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      phase <= '0;
    else if (src_pulse)
      phase <= tick_o ? '0 : phase + PH_W'(1);
  end

  a_r2_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick_o);
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] next_o,
  output logic             inc_evt_o
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  assign next_o    = step(count_o);
  assign inc_evt_o = inc_req && !wr_en;

  always_ff @(posedge clk) begin
    if (!rst_n)
      count_o <= '0;
    else if (wr_en)
      count_o <= wr_data;
    else if (inc_req)
      count_o <= next_o;
  end

  a_r3_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count_o == $past(wr_data));
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_evt_o && (&count_o)) |=> count_o == '0);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_req && !wr_en) |=> $stable(count_o));
endmodule

// File: rtl/rtc_status.sv
module rtc_status
  import rtc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NUM_ALARMS-1:0] wr_clr_alarm,
  input  logic                  wr_clr_tick,
  input  logic [NUM_ALARMS-1:0] wr_en_alarm,
  input  logic                  wr_en_tick,
  input  logic [NUM_ALARMS-1:0] set_match,
  input  logic                  set_tick,
  output logic [NUM_ALARMS-1:0] flag_alarm,
  output logic                  flag_tick,
  output logic [NUM_ALARMS-1:0] en_alarm,
  output logic                  en_tick,
  output logic                  irq_o
);
  logic [NUM_ALARMS-1:0] alarm_req;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_alarm[i] <= 1'b0;
        en_alarm[i]   <= 1'b0;
      end else begin
        // a set in the same cycle beats a write-1 clear
        flag_alarm[i] <= (set_match[i] && en_alarm[i]) ||
                         (flag_alarm[i] && !(wr_en && wr_clr_alarm[i]));
        if (wr_en) en_alarm[i] <= wr_en_alarm[i];
      end
    end
    assign alarm_req[i] = flag_alarm[i] && en_alarm[i];

    a_r5_alarm_set: assert property (@(posedge clk) disable iff (!rst_n)
      (set_match[i] && en_alarm[i]) |=> flag_alarm[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_tick <= 1'b0;
      en_tick   <= 1'b0;
    end else begin
      flag_tick <= set_tick || (flag_tick && !(wr_en && wr_clr_tick));
      if (wr_en) en_tick <= wr_en_tick;
    end
  end

  assign irq_o = (|alarm_req) || (flag_tick && en_tick);

  a_r6_tick_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_tick |=> flag_tick);
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !set_tick) |=> flag_tick == $past(flag_tick));
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_alarm == '0 && !flag_tick) |-> !irq_o);
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_pulse,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int REG_W = 32;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic [DIV_W-1:0]    div_q;
  logic [CLKSEL_W-1:0] clksel_q;
  logic [REG_W-1:0]    scratch_q;
  logic [REG_W-1:0]    alarm_q [NUM_ALARMS];
  logic [REG_W-1:0]    count, count_next;
  logic                tick, inc_evt;
  logic                wr_count, wr_status, wr_div;
  logic [NUM_ALARMS-1:0] match_evt, flag_alarm, en_alarm;
  logic [NUM_ALARMS-1:0] wr_clr_alarm, wr_en_alarm;
  logic                flag_tick, en_tick;
  logic [REG_W-1:0]    status_word;

  assign wr_count  = bus_wr && hit(bus_addr, OFS_COUNT);
  assign wr_status = bus_wr && hit(bus_addr, OFS_STATUS);
  assign wr_div    = bus_wr && hit(bus_addr, OFS_DIVIDER);

  rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .div(div_q), .restart(wr_div), .tick_o(tick)
  );

  rtc_counter #(.CNT_W(REG_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc_req(tick), .wr_en(wr_count),
    .wr_data(bus_wdata), .count_o(count), .next_o(count_next),
    .inc_evt_o(inc_evt)
  );

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    localparam logic [7:0] OFS = (i == 0) ? OFS_ALARM0 : OFS_ALARM1;
    always_ff @(posedge clk) begin
      if (!rst_n)
        alarm_q[i] <= '0;
      else if (bus_wr && hit(bus_addr, OFS))
        alarm_q[i] <= bus_wdata;
    end
    assign match_evt[i]    = inc_evt && (count_next == alarm_q[i]);
    assign wr_clr_alarm[i] = bus_wdata[alarm_flag_bit(i)];
    assign wr_en_alarm[i]  = bus_wdata[alarm_en_bit(i)];
  end

  rtc_status u_stat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_status),
    .wr_clr_alarm(wr_clr_alarm), .wr_clr_tick(bus_wdata[TICK_FLAG_BIT]),
    .wr_en_alarm(wr_en_alarm), .wr_en_tick(bus_wdata[TICK_EN_BIT]),
    .set_match(match_evt), .set_tick(inc_evt),
    .flag_alarm(flag_alarm), .flag_tick(flag_tick),
    .en_alarm(en_alarm), .en_tick(en_tick), .irq_o(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      clksel_q  <= '0;
      scratch_q <= '0;
    end else if (bus_wr) begin
      if (hit(bus_addr, OFS_DIVIDER)) div_q     <= bus_wdata[DIV_W-1:0];
      if (hit(bus_addr, OFS_CLKSEL))  clksel_q  <= bus_wdata[CLKSEL_W-1:0];
      if (hit(bus_addr, OFS_SCRATCH)) scratch_q <= bus_wdata;
    end
  end

  always_comb begin
    status_word = '0;
    status_word[TICK_FLAG_BIT] = flag_tick;
    status_word[TICK_EN_BIT]   = en_tick;
    for (int i = 0; i < NUM_ALARMS; i++) begin
      status_word[alarm_flag_bit(i)] = flag_alarm[i];
      status_word[alarm_en_bit(i)]   = en_alarm[i];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if      (hit(bus_addr, OFS_COUNT))   bus_rdata = count;
    else if (hit(bus_addr, OFS_ALARM0))  bus_rdata = alarm_q[0];
    else if (hit(bus_addr, OFS_STATUS))  bus_rdata = status_word;
    else if (hit(bus_addr, OFS_DIVIDER)) bus_rdata = REG_W'(div_q);
    else if (hit(bus_addr, OFS_ALARM1))  bus_rdata = alarm_q[1];
    else if (hit(bus_addr, OFS_CLKSEL))  bus_rdata = REG_W'(clksel_q);
    else if (hit(bus_addr, OFS_SCRATCH)) bus_rdata = scratch_q;
  end

  a_r6_step_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt |=> status_word[TICK_FLAG_BIT]);
  a_r9_scratch_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit(bus_addr, OFS_SCRATCH)) |=> $stable(scratch_q));
endmodule

// File: tb/sim_rtc_alarm_timer.sv
module sim_rtc_alarm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_pulse = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rtc_alarm_timer u0 (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq)
  );

  localparam int NV = 12;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h40, 8'h1C, 8'h1C, 8'h14, 8'h04, 8'h18,
                                          8'h0C, 8'h08, 8'h08, 8'h00, 8'h24, 8'h0C};
  localparam logic [31:0] V_WR   [NV] = '{32'hDEADBEEF, 32'hFFFFFFFF, 32'h2, 32'hFFFFFFFF,
                                          32'hA5A5A5A5, 32'h0F0F0F0F, 32'hFFFFFFFF,
                                          32'hFFFFFFFF, 32'h0, 32'h12345678, 32'hFFFFFFFF, 32'h0};
  localparam logic [31:0] V_EXP  [NV] = '{32'hDEADBEEF, 32'h3, 32'h2, 32'h0,
                                          32'hA5A5A5A5, 32'h0F0F0F0F, 32'h0000FFFF,
                                          32'h4C, 32'h0, 32'h12345678, 32'h0, 32'h0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); src_pulse = 1'b1;
      @(negedge clk); src_pulse = 1'b0;
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h00, d); check("R1 counter", d, 32'h0);
    rd(8'h08, d); check("R1 status", d, 32'h0);
    rd(8'h40, d); check("R1 scratch", d, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R9 R7 R2 register vectors
    for (int v = 0; v < NV; v++) begin
      wr(V_ADDR[v], V_WR[v]);
      rd(V_ADDR[v], d);
      check($sformatf("R9 vector %0d at %h", v, V_ADDR[v]), d, V_EXP[v]);
    end

    // R2 prescaler period
    wr(8'h0C, 32'h0); wr(8'h00, 32'h0);
    pulses(1); rd(8'h00, d); check("R2 div0 one pulse", d, 32'h0);
    pulses(1); rd(8'h00, d); check("R2 div0 two pulses", d, 32'h1);
    wr(8'h0C, 32'h3);
    pulses(7); rd(8'h00, d); check("R2 div3 seven pulses", d, 32'h1);
    pulses(1); rd(8'h00, d); check("R2 div3 eight pulses", d, 32'h2);

    // R6 tick flag, R7 write-0 keeps, write-1 clears
    rd(8'h08, d); check("R6 tick flag", d, 32'h2);
    wr(8'h08, 32'h0); rd(8'h08, d); check("R7 write0 keeps", d, 32'h2);
    wr(8'h08, 32'h2); rd(8'h08, d); check("R7 write1 clears", d, 32'h0);

    // R4 wrap
    wr(8'h0C, 32'h0); wr(8'h00, 32'hFFFFFFFF);
    pulses(2); rd(8'h00, d); check("R4 wrap", d, 32'h0);
    pulses(2); rd(8'h00, d); check("R4 keeps running", d, 32'h1);

    // R5 alarm 0
    wr(8'h08, 32'h2);
    wr(8'h04, 32'h5); wr(8'h08, 32'h4); wr(8'h00, 32'h3);
    pulses(2); rd(8'h08, d); check("R5 alarm0 before match", d & 32'h1, 32'h0);
    pulses(2); rd(8'h08, d); check("R5 alarm0 match", d, 32'h7);
    check("R8 irq alarm0", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h7); rd(8'h08, d); check("R7 clear keeps enable", d, 32'h4);
    check("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R5 alarm 1 disabled, then enabled, then written match
    wr(8'h18, 32'h7);
    pulses(4); rd(8'h08, d); check("R5 alarm1 disabled", d & 32'h10, 32'h0);
    wr(8'h08, 32'h46); wr(8'h00, 32'h6);
    pulses(2); rd(8'h08, d); check("R5 alarm1 match", d & 32'h10, 32'h10);
    check("R8 irq alarm1", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'h57); rd(8'h08, d); check("R7 alarm1 cleared", d, 32'h44);
    wr(8'h00, 32'h7); rd(8'h08, d); check("R5 write match no flag", d, 32'h44);

    // R8 tick interrupt
    wr(8'h08, 32'h8); wr(8'h0C, 32'h0);
    pulses(2); rd(8'h08, d); check("R8 tick status", d, 32'hA);
    check("R8 irq tick", {31'h0, irq}, 32'h1);
    wr(8'h08, 32'hA); check("R8 irq tick cleared", {31'h0, irq}, 32'h0);

    // R3 write beats a simultaneous step
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0); wr(8'h00, 32'd10);
    pulses(1);
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'd100; bus_wr = 1'b1; src_pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; src_pulse = 1'b0;
    rd(8'h00, d); check("R3 write wins", d, 32'd100);
    rd(8'h08, d); check("R3 no tick on write", d, 32'h0);
    rd(8'h00, d); rd(8'h00, d2); check("R3 reads match", d2, d);
    pulses(2); rd(8'h00, d); check("R3 after write", d, 32'd101);

    // R7 set beats clear in the same cycle
    wr(8'h0C, 32'h0); pulses(1);
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h2; bus_wr = 1'b1; src_pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; src_pulse = 1'b0;
    rd(8'h08, d); check("R7 set beats clear", d, 32'h2);

    // R9 scratch untouched by counting
    rd(8'h40, d); check("R9 scratch kept", d, 32'hDEADBEEF);

    report();
    $finish;
  end
endmodule